// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for a 16-bit-wide asynchronous static RAM inside a clocked design or a testbench. It takes the raw active-low strobes of such a memory (chip select, write strobe, output strobe and one select per byte lane), along with a word address and write data. It returns read data and a per-lane drive flag that models the three-state data pins. A fast sampling clock passes every input through a two-flop synchronizer. All decisions are made on the synchronized copies.

A small state machine classifies each synchronized sample into one of three states. **FLOAT**: no lane is driven. **READ**: lanes whose select is low are driven from the array. **WRITE**: chip select, write strobe and at least one lane select are all low together. The transitions are these. Any state moves to WRITE when that three-way overlap appears. Any state moves to READ when the block is selected, the write strobe is high and the output strobe is low. Otherwise it moves to FLOAT. The WRITE-to-other transition is the commit: on that sample the word and address seen on the last overlap sample are stored into the lanes that were selected then. This means whichever strobe ends the overlap also fixes the captured values. Lanes whose output is not driven read as zero. The array depth is 2^ADDR_W words; ADDR_W = 16 gives the full 65,536-word part.

Top module: `lane_sram_emu`

## Requirements
- R1: The array holds 2^ADDR_W words of 8*LANES bits (default 1024 x 16; 65,536 x 16 with ADDR_W = 16), and each word written at an address reads back from that address without disturbing other addresses.
- R2: While chip select (`cs_n_i`) is high, `drive_o` is 0 and `rdata_o` is 0, whatever the other inputs are.
- R3: With chip select low, write strobe high and output strobe high, both lanes float (`drive_o` = 0, `rdata_o` = 0).
- R4: With chip select low and both lane selects high, both lanes float, and a low write strobe in that condition writes nothing.
- R5: In a read (chip select and output strobe low, write strobe high), `drive_o[0]` is 1 and `rdata_o[7:0]` carries the stored low byte only when `lb_n_i` is low; `drive_o[1]` and `rdata_o[15:8]` behave the same way for `ub_n_i`.
- R6: While the write overlap is active, both lanes float even if the output strobe is low.
- R7: A commit writes only the lanes whose select was low on the last overlap sample; the other lane keeps its stored byte.
- R8: The overlap ends when any one of chip select, write strobe or the last low lane select goes high. The stored word and address are those present just before that change, so address or data changing together with the ending strobe has no effect.
- R9: With the write strobe held low, lane selects alone can frame several back-to-back writes to different addresses.
- R10: An input change is visible at the outputs after the third rising clock edge (two synchronizer stages plus one output register); in particular a read address change shows new data after three edges and not after two.
- R11: When a commit and a read of the same address fall on the same sample, that sample returns the previous word and the next sample returns the new word.
- R12: During and after reset, before any stimulus, `drive_o` is 0, `rdata_o` is 0 and no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address |
| cs_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| ub_n_i | input | 1 | Upper lane select (bits 15:8), active low |
| lb_n_i | input | 1 | Lower lane select (bits 7:0), active low |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero in undriven lanes |
| drive_o | output | 2 | Lane drive flags: bit 0 lower lane, bit 1 upper lane |

## Verification
The commit of a write and a read of the same word can land on the same sample. This happens when the write strobe rises while chip select, output strobe and both lane selects stay low, so the WRITE-to-READ transition and the array read share one clock edge. The bench sets up this case with a known old word already in place. It then requires the old word exactly three edges after the strobe change and the new word on the edge after that. A second overlap is an address or data change made in the same cycle as the ending strobe. It is judged by reading back both the old and the new address.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

    // Bus condition seen on one synchronized sample
    typedef enum logic [1:0] {
        ST_FLOAT = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

    localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/lane_sram_sync.sv
module lane_sram_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl
    import lane_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2,
    parameter int unsigned DATA_W = LANES * LANE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  drive_o,
    output logic [LANES-1:0]  wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic [LANES-1:0]  lanes_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Classify the current synchronized sample
    always_comb begin
        if (cs_n) begin
            state_d = ST_FLOAT;
        end else if (!we_n && (bsel_n != {LANES{1'b1}})) begin
            state_d = ST_WRITE;
        end else if (!we_n || oe_n) begin
            state_d = ST_FLOAT;
        end else begin
            state_d = ST_READ;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOAT;
        end else begin
            state_q <= state_d;
        end
    end

    // Previous-sample lane selects, address and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_q <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            lanes_q <= ~bsel_n;
            addr_q  <= addr;
            data_q  <= wdata;
        end
    end

    // Outputs per state
    always_comb begin
        drive_o = '0;
        wr_en_o = '0;
        unique case (state_q)
            ST_FLOAT: begin
                drive_o = '0;
            end
            ST_READ: begin
                drive_o = lanes_q;
            end
            ST_WRITE: begin
                if (state_d != ST_WRITE) begin
                    wr_en_o = lanes_q;
                end
            end
            default: begin
                drive_o = '0;
            end
        endcase
    end

    assign wr_addr_o = addr_q;
    assign wr_data_o = data_q;

endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned BW     = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BW-1:0]     wr_byte,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BW-1:0]     rd_byte
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [BW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_byte;
        end
    end

    // Read register: sees the array contents before this edge's write
    always_ff @(posedge clk) begin
        rd_byte <= mem[rd_addr];
    end

endmodule

// File: rtl/lane_sram_emu.sv
module lane_sram_emu
    import lane_sram_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        cs_n_i,
    input  logic                        oe_n_i,
    input  logic                        we_n_i,
    input  logic                        ub_n_i,
    input  logic                        lb_n_i,
    input  logic [LANES*LANE_BITS-1:0]  wdata_i,
    output logic [LANES*LANE_BITS-1:0]  rdata_o,
    output logic [LANES-1:0]            drive_o
);

    localparam int unsigned DATA_W = LANES * LANE_BITS;
    localparam int unsigned STRB_W = 3 + LANES;
    localparam int unsigned BUS_W  = ADDR_W + DATA_W;

    logic [LANES-1:0]  bsel_raw;
    logic [STRB_W-1:0] sy_strb;
    logic [BUS_W-1:0]  sy_bus;
    logic              sy_cs_n;
    logic              sy_we_n;
    logic              sy_oe_n;
    logic [LANES-1:0]  sy_bsel_n;
    logic [ADDR_W-1:0] sy_addr;
    logic [DATA_W-1:0] sy_data;
    logic [LANES-1:0]  drive;
    logic [LANES-1:0]  wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    // Lane 0 is the low byte; further lanes above it share the upper select
    generate
        if (LANES == 1) begin : g_one_lane
            assign bsel_raw = lb_n_i;
        end else begin : g_multi_lane
            assign bsel_raw = {{(LANES-1){ub_n_i}}, lb_n_i};
        end
    endgenerate

    lane_sram_sync #(
        .W       (STRB_W),
        .RST_VAL ({STRB_W{1'b1}})
    ) u_sync_strb (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, we_n_i, oe_n_i, bsel_raw}),
        .q_o   (sy_strb)
    );

    lane_sram_sync #(
        .W       (BUS_W),
        .RST_VAL ('0)
    ) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({addr_i, wdata_i}),
        .q_o   (sy_bus)
    );

    assign {sy_cs_n, sy_we_n, sy_oe_n, sy_bsel_n} = sy_strb;
    assign {sy_addr, sy_data} = sy_bus;

    lane_sram_ctrl #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (sy_cs_n),
        .we_n      (sy_we_n),
        .oe_n      (sy_oe_n),
        .bsel_n    (sy_bsel_n),
        .addr      (sy_addr),
        .wdata     (sy_data),
        .drive_o   (drive),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_BITS-1:0] rd_byte;

            lane_sram_bank #(
                .ADDR_W (ADDR_W),
                .BW     (LANE_BITS)
            ) u_bank (
                .clk     (clk),
                .wr_en   (wr_en[g]),
                .wr_addr (wr_addr),
                .wr_byte (wr_data[g*LANE_BITS +: LANE_BITS]),
                .rd_addr (sy_addr),
                .rd_byte (rd_byte)
            );

            assign rdata_o[g*LANE_BITS +: LANE_BITS] = drive[g] ? rd_byte : '0;
        end
    endgenerate

    assign drive_o = drive;

endmodule

// File: rtl/lane_sram_emu_chk.sv
module lane_sram_emu_chk #(
    parameter int unsigned LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sy_cs_n,
    input logic             sy_we_n,
    input logic             sy_oe_n,
    input logic [LANES-1:0] sy_bsel_n,
    input logic [LANES-1:0] wr_en,
    input logic [LANES-1:0] drive_o
);

    logic overlap;
    assign overlap = !sy_cs_n && !sy_we_n && (sy_bsel_n != {LANES{1'b1}});

    assert_desel_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sy_cs_n |=> (drive_o == '0));

    assert_read_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sy_cs_n && sy_we_n && !sy_oe_n) |=> (drive_o == ~$past(sy_bsel_n)));

    assert_write_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overlap |=> (drive_o == '0));

    assert_lane_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & $past(sy_bsel_n)) == '0);

    assert_commit_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!overlap && $past(overlap)) |-> (wr_en != '0));

    assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en != '0) |-> (!overlap && $past(overlap)));

endmodule

bind lane_sram_emu lane_sram_emu_chk #(
    .LANES (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sy_cs_n   (sy_cs_n),
    .sy_we_n   (sy_we_n),
    .sy_oe_n   (sy_oe_n),
    .sy_bsel_n (sy_bsel_n),
    .wr_en     (wr_en),
    .drive_o   (drive_o)
);

// File: tb/lane_sram_emu_test.sv
`timescale 1ns/1ps
module lane_sram_emu_test;

    localparam int unsigned AW = 10;
    localparam logic [AW-1:0] AMAX = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cs_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic          ub_n = 1'b1;
    logic          lb_n = 1'b1;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lane_sram_emu #(.ADDR_W(AW), .LANES(2)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .cs_n_i  (cs_n),
        .oe_n_i  (oe_n),
        .we_n_i  (we_n),
        .ub_n_i  (ub_n),
        .lb_n_i  (lb_n),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .drive_o (drive)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
        wait_n(4);
    endtask

    // endby: 0 lane selects rise, 1 write strobe rises, 2 chip select rises
    task automatic write_word(input logic [AW-1:0] a, input logic [15:0] d,
                              input logic ub, input logic lb, input int endby,
                              input logic [AW-1:0] na, input logic [15:0] nd);
        addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        ub_n = ub; lb_n = lb;
        wait_n(4);
        addr = na; wdata = nd;
        if (endby == 0) begin ub_n = 1'b1; lb_n = 1'b1; end
        else if (endby == 1) we_n = 1'b1;
        else cs_n = 1'b1;
        wait_n(4);
        idle();
    endtask

    task automatic read_expect(input string tag, input logic [AW-1:0] a,
                               input logic ub, input logic lb,
                               input logic [15:0] exp_d, input logic [1:0] exp_drv);
        addr = a; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; ub_n = ub; lb_n = lb;
        wait_n(4);
        check({tag, " data"}, rdata, exp_d);
        check({tag, " drive"}, {14'd0, drive}, {14'd0, exp_drv});
        idle();
    endtask

    task automatic t_reset();
        wait_n(3);
        check("R12 drive in reset", {14'd0, drive}, 16'd0);
        rst_n = 1'b1;
        wait_n(4);
        check("R12 drive after reset", {14'd0, drive}, 16'd0);
        check("R12 rdata after reset", rdata, 16'd0);
    endtask

    task automatic t_basic();
        write_word('0, 16'h1234, 1'b0, 1'b0, 0, '0, 16'h1234);
        write_word(AMAX, 16'hABCD, 1'b0, 1'b0, 0, AMAX, 16'hABCD);
        read_expect("R1 addr 0", '0, 1'b0, 1'b0, 16'h1234, 2'b11);
        read_expect("R1 max addr", AMAX, 1'b0, 1'b0, 16'hABCD, 2'b11);
        read_expect("R5 lower only", '0, 1'b1, 1'b0, 16'h0034, 2'b01);
        read_expect("R5 upper only", '0, 1'b0, 1'b1, 16'h1200, 2'b10);
    endtask

    task automatic t_latency();
        addr = '0; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        wait_n(4);
        addr = AMAX;
        wait_n(2);
        check("R10 two edges old", rdata, 16'h1234);
        wait_n(1);
        check("R10 three edges new", rdata, 16'hABCD);
        idle();
    endtask

    task automatic t_float();
        addr = '0; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0;
        wait_n(4);
        cs_n = 1'b1; we_n = 1'b0;
        wait_n(3);
        check("R2 deselect drive", {14'd0, drive}, 16'd0);
        check("R2 deselect rdata", rdata, 16'd0);
        cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
        wait_n(4);
        check("R3 output disabled", {14'd0, drive}, 16'd0);
        oe_n = 1'b0; ub_n = 1'b1; lb_n = 1'b1;
        wait_n(4);
        check("R4 no lanes read", {14'd0, drive}, 16'd0);
        check("R4 no lanes rdata", rdata, 16'd0);
        idle();
        addr = '0; wdata = 16'hDEAD; cs_n = 1'b0; we_n = 1'b0; ub_n = 1'b1; lb_n = 1'b1;
        wait_n(5);
        idle();
        read_expect("R4 no write", '0, 1'b0, 1'b0, 16'h1234, 2'b11);
    endtask

    task automatic t_write_float();
        addr = 10'd3; wdata = 16'h3333; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        ub_n = 1'b0; lb_n = 1'b0;
        wait_n(4);
        check("R6 write float", {14'd0, drive}, 16'd0);
        check("R6 write rdata", rdata, 16'd0);
        ub_n = 1'b1; lb_n = 1'b1;
        wait_n(4);
        idle();
        read_expect("R6 stored", 10'd3, 1'b0, 1'b0, 16'h3333, 2'b11);
    endtask

    task automatic t_byte_write();
        write_word(10'd5, 16'h5566, 1'b0, 1'b0, 0, 10'd5, 16'h5566);
        write_word(10'd5, 16'h99AA, 1'b1, 1'b0, 0, 10'd5, 16'h99AA);
        read_expect("R7 lower lane only", 10'd5, 1'b0, 1'b0, 16'h55AA, 2'b11);
        write_word(10'd5, 16'h7711, 1'b0, 1'b1, 0, 10'd5, 16'h7711);
        read_expect("R7 upper lane only", 10'd5, 1'b0, 1'b0, 16'h77AA, 2'b11);
    endtask

    task automatic t_terminate();
        write_word(10'd9, 16'h0909, 1'b0, 1'b0, 0, 10'd9, 16'h0909);
        write_word(10'd11, 16'h0B0B, 1'b0, 1'b0, 0, 10'd11, 16'h0B0B);
        write_word(10'd8, 16'h1111, 1'b0, 1'b0, 2, 10'd9, 16'hEEEE);
        read_expect("R8 end by select addr", 10'd8, 1'b0, 1'b0, 16'h1111, 2'b11);
        read_expect("R8 end by select other", 10'd9, 1'b0, 1'b0, 16'h0909, 2'b11);
        write_word(10'd10, 16'h2222, 1'b0, 1'b0, 1, 10'd11, 16'hEEEE);
        read_expect("R8 end by strobe addr", 10'd10, 1'b0, 1'b0, 16'h2222, 2'b11);
        read_expect("R8 end by strobe other", 10'd11, 1'b0, 1'b0, 16'h0B0B, 2'b11);
        write_word(10'd12, 16'h4444, 1'b0, 1'b0, 0, 10'd11, 16'hEEEE);
        read_expect("R8 end by lanes addr", 10'd12, 1'b0, 1'b0, 16'h4444, 2'b11);
        read_expect("R8 end by lanes other", 10'd11, 1'b0, 1'b0, 16'h0B0B, 2'b11);
    endtask

    task automatic t_back_to_back();
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        addr = 10'd20; wdata = 16'hC0DE; ub_n = 1'b0; lb_n = 1'b0;
        wait_n(3);
        ub_n = 1'b1; lb_n = 1'b1;
        wait_n(3);
        addr = 10'd21; wdata = 16'hBEEF; ub_n = 1'b0; lb_n = 1'b0;
        wait_n(3);
        ub_n = 1'b1; lb_n = 1'b1;
        wait_n(3);
        idle();
        read_expect("R9 first word", 10'd20, 1'b0, 1'b0, 16'hC0DE, 2'b11);
        read_expect("R9 second word", 10'd21, 1'b0, 1'b0, 16'hBEEF, 2'b11);
    endtask

    task automatic t_collide();
        write_word(10'd30, 16'h0A0A, 1'b0, 1'b0, 0, 10'd30, 16'h0A0A);
        addr = 10'd30; wdata = 16'h5B5B; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        ub_n = 1'b0; lb_n = 1'b0;
        wait_n(4);
        we_n = 1'b1;
        wait_n(3);
        check("R11 same sample old word", rdata, 16'h0A0A);
        check("R11 same sample drive", {14'd0, drive}, 16'h0003);
        wait_n(1);
        check("R11 next sample new word", rdata, 16'h5B5B);
        idle();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_latency();
        t_float();
        t_write_float();
        t_byte_write();
        t_terminate();
        t_back_to_back();
        t_collide();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule